// File: doc/BRIEF.md
# Crossover Gate Array Fabric

This block is a uniform, pipelined logic fabric. It is built from a fixed grid of two-input gates. The grid has two rows and four stages, and each row holds sixteen gate positions. Every gate in a stage computes the same function, either OR or NOR, and that choice is fixed by a parameter. The gates are not individually programmable. The only customisation is a link-enable mask that can cut any single connection of the crossover network joining one stage to the next.

A word of `in_data` enters the bottom row and crosses all four stages there. The last stage of each row feeds the first stage of the row above it, so the word meets a fresh set of mask words on each pass. The top row's last stage drives `out_data`. Every gate output is registered. A new word can therefore be accepted on every cycle, and words in flight never mix.

Mask words are written through a one-cycle address/data/write-enable port. The fabric reads the stored mask combinationally, so a write affects any gate evaluated on the following cycles.

Top module: `xo_fabric`

## Requirements
- R1: A synchronous active-high `rst` clears every stage register to 0, so `out_data` reads 0 on the first cycle after reset is released.
- R2: With `cfg_we` high, `cfg_wdata` is stored at the next rising edge in mask word `cfg_addr`, where address = row*4 + stage (row 0 is the top row). In that word, bit 2j enables the straight link into column j and bit 2j+1 enables the crossing link into column j.
- R3: Reset sets every mask bit to 1, so all links are enabled.
- R4: A link whose enable bit is 0 contributes logic 0 to the gate it feeds. A stage whose mask word is all zeros therefore outputs all zeros if it is an OR stage and all ones if it is a NOR stage.
- R5: Stage k computes NOR when bit k of parameter `NOR_MAP` is 1, and OR otherwise. The default value 4'b0001 makes stage 0 NOR and stages 1 to 3 OR.
- R6: In stage k, column j takes its straight input from column j of the previous level and its crossing input from column (j XOR 2^k) mod 16.
- R7: A word on `in_data` passes through the bottom row's stages 0 to 3 and then the top row's stages 0 to 3. The bottom row's last stage drives the top row's first stage, and the result appears on `out_data` exactly 8 cycles after it was presented.
- R8: Each pass through the fabric uses the mask words of the row it is travelling on. Changing a bottom-row word changes the result through the first pass only.
- R9: A new word may be presented every cycle, and each result depends only on its own input word and the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mask word write enable |
| cfg_addr | input | 3 | Mask word address, row*4 + stage |
| cfg_wdata | input | 32 | Mask word data, two enable bits per column |
| in_data | input | 16 | Input channel word, entering the bottom row |
| out_data | output | 16 | Output channel word, from the top row's last stage |

## Verification
The write-port assertion assumes that `cfg_addr` stays within the eight existing words while `cfg_we` is high. The bench only ever drives addresses 0 to 7. The scoreboard computes each expected word from the mask contents at the moment the word is driven, so it relies on the mask staying unchanged while a word is in flight. The bench therefore lets the pipeline drain fully before every mask write. The blocked-stage assertions hold whatever data is flowing, and the stimulus covers them with an all-zero word on both an OR stage and a NOR stage.

// File: rtl/xo_pkg.sv
package xo_pkg;

    typedef enum logic {
        GATE_OR  = 1'b0,
        GATE_NOR = 1'b1
    } gate_fn_e;

    // Column that feeds the crossing input of column col in stage lvl
    function automatic int cross_partner(input int col, input int lvl, input int width);
        return (col ^ (1 << lvl)) % width;
    endfunction

endpackage

// File: rtl/xo_mask_store.sv
module xo_mask_store #(
    parameter int WORDS = 8,
    parameter int WBITS = 32,
    parameter int AW    = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [AW-1:0]               addr,
    input  logic [WBITS-1:0]            wdata,
    output logic [WORDS-1:0][WBITS-1:0] mask_o
);

    typedef struct packed {
        logic [WORDS-1:0][WBITS-1:0] words;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && ({1'b0, addr} < (AW+1)'(WORDS))) begin
            st_d.words[addr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.words;

endmodule

// File: rtl/xo_gate_row.sv
module xo_gate_row
    import xo_pkg::*;
#(
    parameter int       WIDTH = 16,
    parameter int       LEVEL = 0,
    parameter gate_fn_e FN    = GATE_OR
) (
    input  logic [WIDTH-1:0]   row_in,
    input  logic [2*WIDTH-1:0] link_en,
    output logic [WIDTH-1:0]   row_out
);

    for (genvar j = 0; j < WIDTH; j++) begin : g_col
        localparam int PARTNER = cross_partner(j, LEVEL, WIDTH);
        logic straight_in;
        logic cross_in;
        assign straight_in = row_in[j]       & link_en[2*j];
        assign cross_in    = row_in[PARTNER] & link_en[2*j+1];
        if (FN == GATE_NOR) begin : g_nor
            assign row_out[j] = ~(straight_in | cross_in);
        end else begin : g_or
            assign row_out[j] = straight_in | cross_in;
        end
    end

endmodule

// File: rtl/xo_fabric.sv
module xo_fabric
    import xo_pkg::*;
#(
    parameter int                  WIDTH   = 16,
    parameter int                  ROWS    = 2,
    parameter int                  STAGES  = 4,
    parameter logic [STAGES-1:0]   NOR_MAP = 4'b0001,
    localparam int                 WORDS   = ROWS * STAGES,
    localparam int                 WBITS   = 2 * WIDTH,
    localparam int                 AW      = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [WBITS-1:0] cfg_wdata,
    input  logic [WIDTH-1:0] in_data,
    output logic [WIDTH-1:0] out_data
);

    typedef struct packed {
        logic [WORDS-1:0][WIDTH-1:0] stage;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [WORDS-1:0][WBITS-1:0] mask_w;
    logic [WORDS-1:0][WIDTH-1:0] gate_out;
    logic [WORDS-1:0][WIDTH-1:0] stage_q;

    xo_mask_store #(
        .WORDS (WORDS),
        .WBITS (WBITS),
        .AW    (AW)
    ) u_mask (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .mask_o (mask_w)
    );

    assign stage_q = pipe_q.stage;

    // Slot r*STAGES+k holds row r, stage k; the bottom row takes the input
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            localparam int SLOT = r * STAGES + k;
            logic [WIDTH-1:0] feed;
            if (k == 0) begin : g_head
                if (r == ROWS - 1) begin : g_entry
                    assign feed = in_data;
                end else begin : g_wrap
                    assign feed = stage_q[(r + 1) * STAGES + STAGES - 1];
                end
            end else begin : g_chain
                assign feed = stage_q[SLOT - 1];
            end

            xo_gate_row #(
                .WIDTH (WIDTH),
                .LEVEL (k),
                .FN    (NOR_MAP[k] ? GATE_NOR : GATE_OR)
            ) u_row (
                .row_in  (feed),
                .link_en (mask_w[SLOT]),
                .row_out (gate_out[SLOT])
            );
        end
    end

    always_comb begin
        pipe_d       = pipe_q;
        pipe_d.stage = gate_out;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_data = stage_q[STAGES - 1];

endmodule

// File: rtl/xo_fabric_chk.sv
module xo_fabric_chk #(
    parameter int                WIDTH   = 16,
    parameter int                ROWS    = 2,
    parameter int                STAGES  = 4,
    parameter logic [STAGES-1:0] NOR_MAP = 4'b0001,
    parameter int                WORDS   = 8,
    parameter int                WBITS   = 32,
    parameter int                AW      = 3
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        cfg_we,
    input logic [AW-1:0]               cfg_addr,
    input logic [WBITS-1:0]            cfg_wdata,
    input logic [WORDS-1:0][WBITS-1:0] mask_w,
    input logic [WORDS-1:0][WIDTH-1:0] stage_q
);

    logic             last_we;
    logic [AW-1:0]    last_addr;
    logic [WBITS-1:0] last_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_we   <= 1'b0;
            last_addr <= '0;
            last_data <= '0;
        end else begin
            last_we   <= cfg_we && ({1'b0, cfg_addr} < (AW+1)'(WORDS));
            last_addr <= cfg_addr;
            last_data <= cfg_wdata;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (stage_q == '0)); // R1

    AST_MASK_RESET_OPEN: assert property (@(posedge clk) rst |=> (mask_w == '1)); // R3

    AST_CFG_STORES: assert property (@(posedge clk) disable iff (rst)
        last_we |-> (mask_w[last_addr] == last_data)); // R2

    for (genvar w = 0; w < WORDS; w++) begin : g_blk
        localparam int LVL = w % STAGES;
        if (NOR_MAP[LVL]) begin : g_nor
            AST_BLOCKED_NOR_ONES: assert property (@(posedge clk) disable iff (rst)
                (mask_w[w] == '0) |=> (stage_q[w] == '1)); // R4
        end else begin : g_or
            AST_BLOCKED_OR_ZERO: assert property (@(posedge clk) disable iff (rst)
                (mask_w[w] == '0) |=> (stage_q[w] == '0)); // R4
        end
    end

endmodule

bind xo_fabric xo_fabric_chk #(
    .WIDTH   (WIDTH),
    .ROWS    (ROWS),
    .STAGES  (STAGES),
    .NOR_MAP (NOR_MAP),
    .WORDS   (WORDS),
    .WBITS   (WBITS),
    .AW      (AW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .mask_w    (mask_w),
    .stage_q   (stage_q)
);

// File: tb/tb_xo_fabric.sv
module tb_xo_fabric;

    localparam int          W      = 16;
    localparam int          NROW   = 2;
    localparam int          NSTG   = 4;
    localparam int          NWORD  = NROW * NSTG;
    localparam int          LAT    = NROW * NSTG;
    localparam logic [3:0]  NORSEL = 4'b0001;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [W-1:0]  in_data = '0;
    logic [W-1:0]  out_data;

    xo_fabric dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .in_data   (in_data),
        .out_data  (out_data)
    );

    always #4 clk = ~clk;

    typedef struct {
        int          due;
        logic [W-1:0] exp;
        string       tag;
    } item_t;

    item_t       sb[$];
    logic [31:0] shadow [NWORD];
    int          cyc = 0;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Independent model built from R4..R7: bottom row first, then the top row
    function automatic logic [W-1:0] model(input logic [W-1:0] x);
        logic [W-1:0] v;
        logic [W-1:0] nv;
        v = x;
        for (int r = NROW - 1; r >= 0; r--) begin
            for (int k = 0; k < NSTG; k++) begin
                for (int j = 0; j < W; j++) begin
                    int  p;
                    logic g;
                    p = (j ^ (1 << k)) % W;
                    g = (v[j] & shadow[r*NSTG+k][2*j]) | (v[p] & shadow[r*NSTG+k][2*j+1]);
                    nv[j] = NORSEL[k] ? ~g : g;
                end
                v = nv;
            end
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                item_t it;
                it = sb.pop_front();
                check(it.due == cyc && out_data === it.exp, it.tag, out_data, it.exp);
            end
        end
    end

    task automatic drive(input logic [W-1:0] x, input string tag);
        item_t it;
        @(negedge clk);
        in_data = x;
        it.due = cyc + LAT;
        it.exp = model(x);
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic drain();
        repeat (LAT + 3) @(negedge clk);
    endtask

    task automatic write_mask(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 3'(a);
        cfg_wdata = d;
        shadow[a] = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", out_data, 16'h0);
        report();
    end

    initial begin
        for (int i = 0; i < NWORD; i++) shadow[i] = '1;   // R3 reset mask state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(out_data === '0, "R1 reset clears pipeline", out_data, '0);

        // R3/R5/R6/R7: default mask, fixed patterns, spaced out
        drive(16'h0000, "R3 R5 all-zero word");
        drain();
        drive(16'hFFFF, "R5 all-one word");
        drain();
        drive(16'h0001, "R6 single low bit");
        drain();
        drive(16'h8000, "R6 single high bit");
        drain();
        drive(16'hA5A5, "R7 mixed pattern");
        drain();

        // R9: back-to-back stream
        for (int i = 0; i < 20; i++) drive(16'($urandom()), "R9 streamed word");
        drain();

        // R2/R8: random mask words on every row and stage
        for (int i = 0; i < NWORD; i++) write_mask(i, $urandom());
        for (int i = 0; i < 24; i++) drive(16'($urandom()), "R2 R8 random mask");
        drain();

        // R6: only crossing links open, straight links cut
        for (int i = 0; i < NWORD; i++) write_mask(i, 32'hAAAA_AAAA);
        for (int i = 0; i < 12; i++) drive(16'($urandom()), "R6 crossing only");
        drain();

        // R4: top row, last OR stage fully blocked -> output 0
        for (int i = 0; i < NWORD; i++) write_mask(i, 32'hFFFF_FFFF);
        write_mask(NSTG - 1, 32'h0);
        for (int i = 0; i < 6; i++) drive(16'($urandom()), "R4 blocked OR stage gives 0");
        drain();
        check(out_data === '0, "R4 blocked OR stage output", out_data, '0);

        // R4/R5: top row NOR stage 0 blocked -> all ones into the OR chain
        write_mask(NSTG - 1, 32'hFFFF_FFFF);
        write_mask(0, 32'h0);
        for (int i = 0; i < 6; i++) drive(16'($urandom()), "R4 R5 blocked NOR stage");
        drain();
        check(out_data === 16'hFFFF, "R4 blocked NOR stage output", out_data, 16'hFFFF);

        // R8: only a bottom-row word changes, the result still follows the model
        write_mask(0, 32'hFFFF_FFFF);
        write_mask(NSTG + 1, 32'h5555_0F0F);
        for (int i = 0; i < 10; i++) drive(16'($urandom()), "R8 bottom row section");
        drain();

        check(sb.size() == 0, "R7 scoreboard empty", 16'(sb.size()), '0);
        report();
    end

endmodule